// File: doc/BRIEF.md
# Windowed Digital Lock Detector

This block tells a phase-locked loop's control logic whether the loop has settled. It watches a reference pulse train and the divided-down feedback pulse train with a fast sampling clock. For each pair of rising edges it counts the sampling ticks between them. Each count is sorted into one of three classes: below the acquire threshold, between the thresholds, or above the release threshold.

The lock indicator rises only after a full evaluation window of comparisons in which every error was below the acquire threshold. It falls as soon as any comparison exceeds the release threshold. It does not wait for the window to end. Errors that fall between the two thresholds keep the current state, which gives the indicator hysteresis.

A feedback edge that never comes is treated as a large error. A control input can hold the indicator low at any time. Deasserting the enable clears the verdict and starts a new window. The reference and feedback inputs are assumed to be already synchronous to the sampling clock.

Top module: `lock_window_detector`

## Requirements
- R1: While `rst` is high, and at the first clock after it, `lock_o` is 0.
- R2: The phase error is the number of sampling ticks between the rising edges of `ref_in` and `fb_in`, whichever edge comes first. Rising edges in the same tick give an error of 0.
- R3: `lock_o` rises only at the end of an evaluation window of `WIN_CYCLES` comparisons (default 64) in which every error was strictly below `TW1_TICKS`. After 63 clean comparisons of a fresh window it is still 0.
- R4: A comparison whose error is strictly above `TW2_TICKS` drives `lock_o` to 0 within four clock edges of the edge that samples the late input edge. It does not wait for the end of the window.
- R5: Errors from `TW1_TICKS` to `TW2_TICKS` inclusive leave a high `lock_o` high. The same errors keep a low `lock_o` low at the end of that window.
- R6: A reference edge is a large error, even with no threshold crossed, in two cases. The first is a second reference edge arriving before its feedback partner. The second is no partner edge arriving within `MAX_TICKS` ticks.
- R7: While `force_low` is 1, `lock_o` is 0 from the next clock edge onward. Window evaluation keeps running, so when `force_low` is released `lock_o` shows the held verdict one edge later.
- R8: When `en` is 0, `lock_o` is 0 at the next edge and all window state is cleared. After `en` returns to 1, a fresh full window is needed before `lock_o` can rise.
- R9: The thresholds are parameters counted in ticks. An error equal to `TW1_TICKS` is not below it, and an error equal to `TW2_TICKS` is not above it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference pulse train |
| fb_in | input | 1 | Divided feedback pulse train |
| en | input | 1 | Detector enable; 0 clears the verdict and restarts the window |
| force_low | input | 1 | Holds the lock indicator low |
| lock_o | output | 1 | Registered lock indicator |

## Verification
The bench builds the detector with `TW1_TICKS`=3, `TW2_TICKS`=6 and `MAX_TICKS`=40, and keeps the 64-comparison window. The separated thresholds leave room to place errors of exactly 3 and exactly 6, which probes both threshold boundaries and the hold band between them. The short timeout lets a lone reference edge be declared lost in about forty ticks, so that path is tested apart from the repeated-reference path. The reference period is 20 ticks, so feedback can lead or lag by up to seven ticks inside one period.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  // Classification of one measured phase error
  typedef enum logic [1:0] {
    ERR_SMALL = 2'd0,   // strictly below the acquire threshold
    ERR_MID   = 2'd1,   // inside the hysteresis band
    ERR_BIG   = 2'd2    // above the release threshold, or partner edge lost
  } err_class_t;
endpackage

// File: rtl/lockdet_rise.sv
module lockdet_rise #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (clr) begin
        prev[i] <= 1'b0;
        rise[i] <= 1'b0;
      end else begin
        prev[i] <= sig[i];
        rise[i] <= sig[i] & ~prev[i];
      end
    end
  end
endmodule

// File: rtl/lockdet_phase_meter.sv
module lockdet_phase_meter
  import lockdet_pkg::*;
#(
  parameter int TW1_TICKS = 3,
  parameter int TW2_TICKS = 3,
  parameter int MAX_TICKS = 255,
  parameter int CNT_W     = $clog2(MAX_TICKS + 1)
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       ref_e,
  input  logic       fb_e,
  output logic       smp_vld,
  output err_class_t smp_cls
);
  localparam logic [CNT_W:0]   TW1_V    = (CNT_W+1)'(TW1_TICKS);
  localparam logic [CNT_W:0]   TW2_V    = (CNT_W+1)'(TW2_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_TICKS - 1);

  logic             busy;     // an anchor edge is waiting for its partner
  logic             anc_ref;  // 1: anchor is reference, 0: anchor is feedback
  logic [CNT_W-1:0] cnt;
  logic             own_e, partner_e;

  assign own_e     = anc_ref ? ref_e : fb_e;
  assign partner_e = anc_ref ? fb_e  : ref_e;

  function automatic err_class_t classify(input logic [CNT_W:0] e);
    if (e < TW1_V)      return ERR_SMALL;
    else if (e > TW2_V) return ERR_BIG;
    else                return ERR_MID;
  endfunction

  always_ff @(posedge clk) begin
    if (clr) begin
      busy    <= 1'b0;
      anc_ref <= 1'b1;
      cnt     <= '0;
      smp_vld <= 1'b0;
      smp_cls <= ERR_SMALL;
    end else begin
      smp_vld <= 1'b0;
      if (!busy) begin
        if (ref_e && fb_e) begin
          smp_vld <= 1'b1;
          smp_cls <= classify('0);
        end else if (ref_e || fb_e) begin
          busy    <= 1'b1;
          anc_ref <= ref_e;
          cnt     <= '0;
        end
      end else if (own_e) begin
        // anchor repeated before its partner: lost edge, re-anchor here
        smp_vld <= 1'b1;
        smp_cls <= ERR_BIG;
        cnt     <= '0;
      end else if (partner_e) begin
        smp_vld <= 1'b1;
        smp_cls <= classify({1'b0, cnt} + 1'b1);
        busy    <= 1'b0;
      end else if (cnt == CNT_LAST) begin
        smp_vld <= 1'b1;
        smp_cls <= ERR_BIG;
        busy    <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: a partner that does not come in time yields a large error
  assert_timeout_big_R6: assert property (@(posedge clk) disable iff (clr)
    (busy && cnt == CNT_LAST && !own_e && !partner_e) |=> (smp_vld && smp_cls == ERR_BIG));

  // R6: repeated anchor edge yields a large error
  assert_repeat_big_R6: assert property (@(posedge clk) disable iff (clr)
    (busy && own_e) |=> (smp_vld && smp_cls == ERR_BIG));
endmodule

// File: rtl/lockdet_window_judge.sv
module lockdet_window_judge
  import lockdet_pkg::*;
#(
  parameter int WIN_CYCLES = 64,
  parameter int IDX_W      = $clog2(WIN_CYCLES)
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       smp_vld,
  input  err_class_t smp_cls,
  output logic       lock_q
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WIN_CYCLES - 1);

  logic [IDX_W-1:0] idx;
  logic             dirty;  // some sample of this window was not small

  always_ff @(posedge clk) begin
    if (clr) begin
      idx    <= '0;
      dirty  <= 1'b0;
      lock_q <= 1'b0;
    end else if (smp_vld) begin
      if (smp_cls == ERR_BIG) lock_q <= 1'b0;
      if (idx == IDX_LAST) begin
        idx   <= '0;
        dirty <= 1'b0;
        if (!dirty && smp_cls == ERR_SMALL) lock_q <= 1'b1;
      end else begin
        idx   <= idx + 1'b1;
        dirty <= dirty | (smp_cls != ERR_SMALL);
      end
    end
  end

  // R3: lock can only rise on the closing sample of a window
  assert_rise_at_window_end_R3: assert property (@(posedge clk) disable iff (clr)
    $rose(lock_q) |-> $past(smp_vld && idx == IDX_LAST && smp_cls == ERR_SMALL));

  // R4: a large error drops the verdict on the next edge
  assert_big_drops_R4: assert property (@(posedge clk) disable iff (clr)
    (smp_vld && smp_cls == ERR_BIG) |=> !lock_q);
endmodule

// File: rtl/lock_window_detector.sv
module lock_window_detector
  import lockdet_pkg::*;
#(
  parameter int WIN_CYCLES = 64,
  parameter int TW1_TICKS  = 3,
  parameter int TW2_TICKS  = 3,
  parameter int MAX_TICKS  = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  input  logic en,
  input  logic force_low,
  output logic lock_o
);
  localparam int CNT_W = $clog2(MAX_TICKS + 1);
  localparam int IDX_W = $clog2(WIN_CYCLES);

  logic       clr;
  logic [1:0] rise;
  logic       smp_vld;
  err_class_t smp_cls;
  logic       verdict;

  assign clr = rst | ~en;

  lockdet_rise #(.N(2)) u_rise (
    .clk  (clk),
    .clr  (clr),
    .sig  ({fb_in, ref_in}),
    .rise (rise)
  );

  lockdet_phase_meter #(
    .TW1_TICKS (TW1_TICKS),
    .TW2_TICKS (TW2_TICKS),
    .MAX_TICKS (MAX_TICKS),
    .CNT_W     (CNT_W)
  ) u_meter (
    .clk     (clk),
    .clr     (clr),
    .ref_e   (rise[0]),
    .fb_e    (rise[1]),
    .smp_vld (smp_vld),
    .smp_cls (smp_cls)
  );

  lockdet_window_judge #(
    .WIN_CYCLES (WIN_CYCLES),
    .IDX_W      (IDX_W)
  ) u_judge (
    .clk     (clk),
    .clr     (clr),
    .smp_vld (smp_vld),
    .smp_cls (smp_cls),
    .lock_q  (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) lock_o <= 1'b0;
    else     lock_o <= en & ~force_low & verdict;
  end

  // R7: forcing holds the indicator low
  assert_force_low_R7: assert property (@(posedge clk) disable iff (rst)
    force_low |=> !lock_o);

  // R8: disabling clears the indicator
  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !lock_o);

  // R1: reset leaves the indicator low
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !lock_o);
endmodule

// File: tb/lock_window_detector_tb.sv
module lock_window_detector_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, fb_in = 1'b0, en = 1'b0, force_low = 1'b0;
  logic lock_o;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  lock_window_detector #(
    .WIN_CYCLES (64), .TW1_TICKS (3), .TW2_TICKS (6), .MAX_TICKS (40)
  ) u_dut (
    .clk (clk), .rst (rst), .ref_in (ref_in), .fb_in (fb_in),
    .en (en), .force_low (force_low), .lock_o (lock_o)
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: lock_o=%b expected=%b", req, what, got, exp);
    end
  endtask

  // One 20-tick period: reference rises at tick 8, feedback at 8+d
  task automatic period(input int d, input bit send_fb);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ref_in = (i >= 8 && i < 10);
      fb_in  = send_fb && (i >= 8 + d) && (i < 10 + d);
    end
  endtask

  task automatic periods(input int n, input int d);
    for (int k = 0; k < n; k++) period(d, 1'b1);
  endtask

  task automatic restart();
    @(negedge clk);
    en = 1'b0; ref_in = 1'b0; fb_in = 1'b0; force_low = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
  endtask

  task automatic acquire();
    restart();
    periods(64, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(lock_o, 1'b0, "R1", "during reset");
    rst = 1'b0; en = 1'b1;
    @(negedge clk);
    check(lock_o, 1'b0, "R1", "after reset");
  endtask

  task automatic t_acquire();
    restart();
    periods(63, 1);
    check(lock_o, 1'b0, "R3", "63 clean comparisons");
    periods(1, 1);
    check(lock_o, 1'b1, "R3", "64 clean comparisons");
  endtask

  task automatic t_hold_band();
    period(4, 1'b1);
    period(6, 1'b1);   // equals TW2: not above
    periods(62, 2);
    check(lock_o, 1'b1, "R5", "hold band keeps lock");
    check(lock_o, 1'b1, "R9", "error equal TW2 not large");
  endtask

  task automatic t_drop();
    periods(5, 1);
    period(7, 1'b1);
    check(lock_o, 1'b0, "R4", "error 7 drops lock mid window");
  endtask

  task automatic t_block_acquire();
    restart();
    period(3, 1'b1);   // equals TW1: not below
    periods(63, 0);
    check(lock_o, 1'b0, "R9", "error equal TW1 blocks acquire");
    periods(64, 0);
    check(lock_o, 1'b1, "R2", "coincident edges acquire");
  endtask

  task automatic t_fb_leads();
    restart();
    periods(64, -2);
    check(lock_o, 1'b1, "R2", "feedback leading by 2");
    period(-7, 1'b1);
    check(lock_o, 1'b0, "R2", "feedback leading by 7 drops");
  endtask

  task automatic t_missing();
    acquire();
    period(0, 1'b0);
    check(lock_o, 1'b1, "R6", "one pending reference");
    period(0, 1'b0);
    check(lock_o, 1'b0, "R6", "second reference without feedback");
  endtask

  task automatic t_timeout();
    acquire();
    period(0, 1'b0);
    ref_in = 1'b0;
    repeat (15) @(negedge clk);
    check(lock_o, 1'b1, "R6", "before timeout");
    repeat (30) @(negedge clk);
    check(lock_o, 1'b0, "R6", "after timeout");
  endtask

  task automatic t_force();
    acquire();
    force_low = 1'b1;
    @(negedge clk);
    check(lock_o, 1'b0, "R7", "forced low");
    periods(3, 1);
    check(lock_o, 1'b0, "R7", "stays forced");
    force_low = 1'b0;
    @(negedge clk);
    check(lock_o, 1'b1, "R7", "released shows held verdict");
  endtask

  task automatic t_disable();
    acquire();
    en = 1'b0;
    @(negedge clk);
    check(lock_o, 1'b0, "R8", "disable clears");
    en = 1'b1;
    periods(63, 1);
    check(lock_o, 1'b0, "R8", "window restarted");
    periods(1, 1);
    check(lock_o, 1'b1, "R8", "full window after enable");
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_hold_band();
    t_drop();
    t_block_acquire();
    t_fb_leads();
    t_missing();
    t_timeout();
    t_force();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule